// File: doc/BRIEF.md
# Two-Wire Scan Packet Engine

This block moves one TAP state's worth of test data across a two-wire link made of a test clock line and a single bidirectional mode/data line. Each transfer is started by a valid/ready handshake that carries the user's TDI and TMS values for that state. The engine then runs the link clock for a fixed number of periods. It first sends a delay element of at least six clock periods and then a six-bit scan packet. In the two leading bit periods the controller drives the data line. In the four trailing periods the controller releases the line, and the target returns its program-counter flags, its ready flag and its TDO value.

Transfers are refused unless a format-select input shows that this packet format has been chosen. While no packet is in flight, the link clock is held low and the data line is driven high. When the fourth read bit has been sampled, the four returned bits appear together with a single-cycle result strobe. They hold their value until the next result.

Top module: `mscan_engine`

## Requirements
- R1: `in_ready` is high only while `fmt_mscan` is high and no packet is in flight. With `fmt_mscan` low, a request on `in_valid` is not accepted: `tckc` stays low and `tmsc_oe` stays high.
- R2: `tckc` is low whenever no packet is in flight. During a packet, each link clock period lasts 2*HALF_DIV cycles of `clk`, with the low half first. The first rising edge follows the accepting clock edge by HALF_DIV cycles.
- R3: Each packet begins with a delay element of DLY_TCK link clock periods (DLY_TCK at least 6). Throughout the delay element `tmsc_oe`=1 and `tmsc_out`=1.
- R4: The first packet bit period carries the inverse of the accepted `in_tdi`. The second carries the accepted `in_tms`. In both, `tmsc_oe`=1.
- R5: In packet bit periods 3 to 6, `tmsc_oe`=0. `tmsc_in` is sampled at each rising edge of `tckc`, in the order PC0, RDY, PC1, TDO.
- R6: `res_valid` is a one-cycle pulse that is high in the cycle right after the rising edge that samples TDO. At that point `res_pc0`, `res_rdy`, `res_pc1` and `res_tdo` show the four sampled bits, and they hold those values until the next pulse.
- R7: `tmsc_oe` and `tmsc_out` change only at falling edges of `tckc`. They stay stable while `tckc` is high.
- R8: An accepted request produces exactly DLY_TCK+6 rising edges of `tckc`. `in_ready` goes low after the accepting edge. It returns high 2*HALF_DIV*(DLY_TCK+6) cycles after that edge.
- R9: After reset, `tckc`=0, `tmsc_oe`=1, `tmsc_out`=1, `res_valid`=0, all result bits are 0, and `in_ready` follows `fmt_mscan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_mscan | input | 1 | Format selected; allows transfers |
| in_valid | input | 1 | Request for one TAP state transfer |
| in_ready | output | 1 | Engine can accept a request |
| in_tdi | input | 1 | User TDI value for the state |
| in_tms | input | 1 | User TMS value for the state |
| tckc | output | 1 | Link test clock |
| tmsc_oe | output | 1 | Data line output enable |
| tmsc_out | output | 1 | Data line driven value |
| tmsc_in | input | 1 | Data line received value |
| res_valid | output | 1 | Result strobe, one cycle |
| res_pc0 | output | 1 | Returned PC0 bit |
| res_rdy | output | 1 | Returned ready bit |
| res_pc1 | output | 1 | Returned PC1 bit |
| res_tdo | output | 1 | Returned TDO bit |

## Verification
Cycles are counted from the clock edge that accepts a request. The first link rising edge is due HALF_DIV cycles later. Each later edge follows a whole link period after the one before it. The result strobe is due in the very cycle in which the final rising edge becomes visible, and `in_ready` comes back 2*HALF_DIV*(DLY_TCK+6) cycles after acceptance. The bench samples at falling edges of `clk`, finds the link edges by comparing `tckc` with its previous sample, and indexes every expectation by rising-edge number and by elapsed cycle count instead of waiting loosely for an event. As a result, an early or late strobe, slot or ready signal is reported.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DLY  = 2'd1,
      PH_BITS = 2'd2
   } mscan_phase_e;

   localparam int PKT_BITS = 6;
   localparam int DRV_BITS = 2;
   localparam int RD_BITS  = PKT_BITS - DRV_BITS;
   localparam int MIN_DLY  = 6;
endpackage

// File: rtl/mscan_clkgen.sv
module mscan_clkgen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tckc,
   output logic rise,
   output logic fall
);
   logic tick;

   generate
      if (HALF_DIV == 1) begin : g_fast
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt <= '0;
            end else if (cnt == CW'(HALF_DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = run && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   assign rise = tick && !tckc;
   assign fall = tick && tckc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         tckc <= 1'b0;
      end else if (tick) begin
         tckc <= !tckc;
      end
   end
endmodule

// File: rtl/mscan_seq.sv
module mscan_seq
   import mscan_pkg::*;
#(
   parameter int DLY_TCK = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         fall,
   input  logic         tdi,
   input  logic         tms,
   output mscan_phase_e phase,
   output logic [2:0]   bit_idx,
   output logic         tdi_q,
   output logic         tms_q
);
   localparam int SW = $clog2(DLY_TCK);

   logic [SW-1:0] dly_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         dly_cnt <= '0;
         bit_idx <= '0;
         tdi_q   <= 1'b0;
         tms_q   <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_DLY;
                  dly_cnt <= '0;
                  bit_idx <= '0;
                  tdi_q   <= tdi;
                  tms_q   <= tms;
               end
            end
            PH_DLY: begin
               if (fall) begin
                  if (dly_cnt == SW'(DLY_TCK - 1)) begin
                     phase   <= PH_BITS;
                     bit_idx <= '0;
                  end else begin
                     dly_cnt <= dly_cnt + 1'b1;
                  end
               end
            end
            PH_BITS: begin
               if (fall) begin
                  if (bit_idx == 3'(PKT_BITS - 1)) begin
                     phase <= PH_IDLE;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mscan_capture.sv
module mscan_capture
   import mscan_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise,
   input  logic               rd_slot,
   input  logic               last_slot,
   input  logic               din,
   output logic               res_valid,
   output logic [RD_BITS-1:0] res_bits
);
   logic [RD_BITS-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         res_bits  <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (rise && rd_slot) begin
            shreg <= {shreg[RD_BITS-2:0], din};
            if (last_slot) begin
               res_bits  <= {shreg[RD_BITS-2:0], din};
               res_valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mscan_engine.sv
module mscan_engine
   import mscan_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int DLY_TCK  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fmt_mscan,
   input  logic in_valid,
   output logic in_ready,
   input  logic in_tdi,
   input  logic in_tms,
   output logic tckc,
   output logic tmsc_oe,
   output logic tmsc_out,
   input  logic tmsc_in,
   output logic res_valid,
   output logic res_pc0,
   output logic res_rdy,
   output logic res_pc1,
   output logic res_tdo
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (DLY_TCK < MIN_DLY) begin : g_bad_dly
         $error("DLY_TCK must be at least 6");
      end
   endgenerate

   mscan_phase_e       phase;
   logic [2:0]         bit_idx;
   logic               tdi_q, tms_q;
   logic               rise, fall, run, start;
   logic               rd_slot, last_slot;
   logic [RD_BITS-1:0] res_bits;

   assign run      = (phase != PH_IDLE);
   assign in_ready = fmt_mscan && (phase == PH_IDLE);
   assign start    = in_valid && in_ready;

   mscan_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tckc (tckc),
      .rise (rise),
      .fall (fall)
   );

   mscan_seq #(.DLY_TCK(DLY_TCK)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .fall   (fall),
      .tdi    (in_tdi),
      .tms    (in_tms),
      .phase  (phase),
      .bit_idx(bit_idx),
      .tdi_q  (tdi_q),
      .tms_q  (tms_q)
   );

   assign rd_slot   = (phase == PH_BITS) && (bit_idx >= 3'(DRV_BITS));
   assign last_slot = (phase == PH_BITS) && (bit_idx == 3'(PKT_BITS - 1));

   mscan_capture u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .rd_slot  (rd_slot),
      .last_slot(last_slot),
      .din      (tmsc_in),
      .res_valid(res_valid),
      .res_bits (res_bits)
   );

   always_comb begin
      tmsc_oe  = 1'b1;
      tmsc_out = 1'b1;
      if (phase == PH_BITS) begin
         if (bit_idx == 3'd0) begin
            tmsc_out = !tdi_q;
         end else if (bit_idx == 3'd1) begin
            tmsc_out = tms_q;
         end else begin
            tmsc_oe  = 1'b0;
            tmsc_out = 1'b0;
         end
      end
   end

   assign res_pc0 = res_bits[3];
   assign res_rdy = res_bits[2];
   assign res_pc1 = res_bits[1];
   assign res_tdo = res_bits[0];
endmodule

// File: rtl/mscan_engine_chk.sv
module mscan_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic fmt_mscan,
   input logic in_valid,
   input logic in_ready,
   input logic tckc,
   input logic tmsc_oe,
   input logic tmsc_out,
   input logic res_valid
);
   // R1
   ready_needs_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> fmt_mscan);

   // R2
   idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !tckc);

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R6
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R5
   res_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!tmsc_oe && tckc));

   // R7
   high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tckc && $past(tckc)) |-> ($stable(tmsc_oe) && $stable(tmsc_out)));
endmodule

bind mscan_engine mscan_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fmt_mscan(fmt_mscan),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tckc     (tckc),
   .tmsc_oe  (tmsc_oe),
   .tmsc_out (tmsc_out),
   .res_valid(res_valid)
);

// File: tb/mscan_engine_tb.sv
`timescale 1ns/1ps
module mscan_engine_tb;
   localparam int HALF_DIV = 2;
   localparam int DLY_TCK  = 6;
   localparam int NPER     = DLY_TCK + 6;
   localparam int PKT_CYC  = 2 * HALF_DIV * NPER;

   logic clk = 1'b0;
   logic rst_n, fmt_mscan, in_valid, in_ready, in_tdi, in_tms;
   logic tckc, tmsc_oe, tmsc_out, tmsc_in;
   logic res_valid, res_pc0, res_rdy, res_pc1, res_tdo;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = !clk;

   mscan_engine #(.HALF_DIV(HALF_DIV), .DLY_TCK(DLY_TCK)) u_dut (
      .clk(clk), .rst_n(rst_n), .fmt_mscan(fmt_mscan),
      .in_valid(in_valid), .in_ready(in_ready), .in_tdi(in_tdi), .in_tms(in_tms),
      .tckc(tckc), .tmsc_oe(tmsc_oe), .tmsc_out(tmsc_out), .tmsc_in(tmsc_in),
      .res_valid(res_valid), .res_pc0(res_pc0), .res_rdy(res_rdy),
      .res_pc1(res_pc1), .res_tdo(res_tdo)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] res_vec();
      return {res_pc0, res_rdy, res_pc1, res_tdo};
   endfunction

   task automatic packet(input logic tdi, input logic tms, input logic [3:0] rdv);
      int k, rises, ready_at, first_rise, idx, j;
      logic prev, cur, last_oe, last_out;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_tdi   = tdi;
      in_tms   = tms;
      tmsc_in  = rdv[3];
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      // R8: busy right after acceptance
      chk(in_ready == 1'b0, "R8", int'(in_ready), 0);
      k = 0; rises = 0; ready_at = -1; first_rise = -1;
      prev = tckc; last_oe = tmsc_oe; last_out = tmsc_out;
      while (k < PKT_CYC + 20 && ready_at < 0) begin
         @(negedge clk);
         k++;
         cur = tckc;
         if (prev && cur) begin
            // R7: line stable during high half
            chk(tmsc_oe == last_oe && tmsc_out == last_out, "R7",
                int'({tmsc_oe, tmsc_out}), int'({last_oe, last_out}));
         end
         if (!prev && cur) begin
            idx = rises;
            rises++;
            if (first_rise < 0) first_rise = k;
            if (idx < DLY_TCK) begin
               // R3: delay element drives high
               chk(tmsc_oe && tmsc_out, "R3", int'({tmsc_oe, tmsc_out}), 3);
            end else if (idx == DLY_TCK) begin
               // R4: inverted TDI
               chk(tmsc_oe && tmsc_out == !tdi, "R4", int'({tmsc_oe, tmsc_out}),
                   int'({1'b1, !tdi}));
            end else if (idx == DLY_TCK + 1) begin
               // R4: TMS
               chk(tmsc_oe && tmsc_out == tms, "R4", int'({tmsc_oe, tmsc_out}),
                   int'({1'b1, tms}));
            end else begin
               j = idx - DLY_TCK - 2;
               // R5: line released in read bits
               chk(tmsc_oe == 1'b0, "R5", int'(tmsc_oe), 0);
               if (j < 3) tmsc_in = rdv[2-j];
               if (j == 3) begin
                  // R6: strobe with all four bits in order PC0,RDY,PC1,TDO
                  chk(res_valid == 1'b1, "R6", int'(res_valid), 1);
                  chk(res_vec() == rdv, "R5", int'(res_vec()), int'(rdv));
               end
            end
            if (idx != DLY_TCK + 5) chk(res_valid == 1'b0, "R6", int'(res_valid), 0);
         end else if (res_valid) begin
            chk(1'b0, "R6", 1, 0);
         end
         if (in_ready && ready_at < 0) ready_at = k;
         prev = cur; last_oe = tmsc_oe; last_out = tmsc_out;
      end
      // R2: first rising edge timing
      chk(first_rise == HALF_DIV, "R2", first_rise, HALF_DIV);
      // R8: edge count and return of ready
      chk(rises == NPER, "R8", rises, NPER);
      chk(ready_at == PKT_CYC, "R8", ready_at, PKT_CYC);
      // R2: clock parked low
      chk(tckc == 1'b0, "R2", int'(tckc), 0);
      // R6: result holds after the pulse
      chk(res_vec() == rdv && !res_valid, "R6", int'(res_vec()), int'(rdv));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      rst_n = 1'b0; fmt_mscan = 1'b1; in_valid = 1'b0;
      in_tdi = 1'b0; in_tms = 1'b0; tmsc_in = 1'b0;
      void'($urandom(32'h5eed_0042));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(tckc == 1'b0, "R9", int'(tckc), 0);
      chk(tmsc_oe && tmsc_out, "R9", int'({tmsc_oe, tmsc_out}), 3);
      chk(!res_valid && res_vec() == 4'h0, "R9", int'(res_vec()), 0);
      chk(in_ready == 1'b1, "R9", int'(in_ready), 1);

      // R1: format not selected, requests ignored
      fmt_mscan = 1'b0;
      in_valid  = 1'b1;
      in_tdi    = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         chk(!in_ready && !tckc && tmsc_oe && tmsc_out, "R1",
             int'({in_ready, tckc, tmsc_oe}), 1);
      end
      in_valid  = 1'b0;
      fmt_mscan = 1'b1;
      @(negedge clk);
      chk(res_vec() == 4'h0 && in_ready, "R1", int'(res_vec()), 0);

      // directed corners
      packet(1'b0, 1'b0, 4'h0);
      packet(1'b1, 1'b1, 4'hF);
      packet(1'b0, 1'b1, 4'hA);
      packet(1'b1, 1'b0, 4'h5);

      // constrained random
      for (int n = 0; n < 24; n++) begin
         r = $urandom();
         packet(r[0], r[1], r[5:2]);
         repeat (r[8:6]) @(negedge clk);
      end

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule